// File: doc/BRIEF.md
# Page Table Entry Generator

This block fills a region of memory with 64-bit page-table entries that it computes itself. A command gives a destination byte address, a starting value, a step, an OR-mask and a count. When the start strobe is accepted the block latches the command and then emits one write beat per entry. Each entry is the running value with the mask ORed on top. Beats go to consecutive 8-byte slots, one after another.

The write port uses a valid/ready handshake. A stalled beat holds its address and data, and the block computes nothing new until that beat is taken. After the final beat is accepted, the block raises a completion pulse for one cycle and then returns to idle. The programmed count is one less than the number of entries, so a count of zero writes exactly one entry. The running value is kept in an accumulator that adds the step after every accepted beat, so the block needs no multiplier.

Top module: `pte_gen`

## Requirements
- R1: After reset, wr_valid_o, done_o and busy_o are all 0.
- R2: A command with count field N produces exactly N+1 accepted write beats before done_o is raised.
- R3: The data of beat i (i counted from 0) equals mask OR (initial + i*increment), with the sum and product taken modulo 2^64.
- R4: The address of beat i equals dest + 8*i, taken modulo 2^ADDR_W.
- R5: done_o is high for exactly one cycle. That cycle is the one directly after the cycle in which the last beat is accepted (wr_valid_o and wr_ready_i both 1). done_o is never high at any other time.
- R6: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o stays 1 and wr_addr_o and wr_data_o stay unchanged in the next cycle.
- R7: A start_i pulse while busy_o is 1, including during the done_o cycle, is ignored. It adds no beats, it does not change the running command, and no beat follows it.
- R8: The accumulator and the address both wrap around without a gap: entries past 2^64-1 and addresses past 2^ADDR_W-1 continue from zero.
- R9: A count field of 0 produces a single beat carrying mask OR initial at address dest.
- R10: busy_o is 1 from the cycle after an accepted start through the done_o cycle, and wr_valid_o is never 1 while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken only when idle |
| dest_i | input | ADDR_W | Destination byte address of the first entry |
| init_i | input | 64 | Initial value of the sequence |
| incr_i | input | 64 | Step added after each entry |
| mask_i | input | 64 | Bits ORed onto every entry |
| count_i | input | CNT_W | Number of entries minus one |
| busy_o | output | 1 | Command in progress |
| wr_valid_o | output | 1 | Write beat offered |
| wr_ready_i | input | 1 | Write beat accepted when high with wr_valid_o |
| wr_addr_o | output | ADDR_W | Byte address of the offered beat |
| wr_data_o | output | 64 | Entry of the offered beat |
| done_o | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The bench builds the block with ADDR_W=16 and CNT_W=5. The narrow address lets a run cross the top of the address space within a few beats. The narrow count lets the largest command (32 entries) run in full. With these values the bench can reach address wrap, value wrap past 2^64, the single-entry case and the full-count case in well under a thousand cycles. It uses each of these together with always-ready, random and periodic backpressure, and it fires stray start pulses both in mid-run and in the completion cycle.

// File: rtl/pte_gen_pkg.sv
package pte_gen_pkg;
  localparam int unsigned ENTRY_W     = 64;
  localparam int unsigned ENTRY_BYTES = ENTRY_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pte_state_e;
endpackage

// File: rtl/pte_gen_ctrl.sv
module pte_gen_ctrl
  import pte_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             beat_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             done_o
);
  pte_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             last_beat;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign run_o     = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign last_beat = beat_i && (left_q == '0);

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        left_d  = count_i;
      end
      ST_RUN: if (last_beat) begin
        state_d = ST_DONE;
      end else if (beat_i) begin
        left_d = left_q - 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
    end
  end
endmodule

// File: rtl/pte_gen_acc.sv
module pte_gen_acc
  import pte_gen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [ENTRY_W-1:0] init_i,
  input  logic [ENTRY_W-1:0] incr_i,
  input  logic [ENTRY_W-1:0] mask_i,
  output logic [ENTRY_W-1:0] entry_o
);
  logic [ENTRY_W-1:0] acc_q, incr_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      incr_q <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      acc_q  <= init_i;
      incr_q <= incr_i;
      mask_q <= mask_i;
    end else if (step_i) begin
      acc_q <= acc_q + incr_q;  // wraps mod 2^64
    end
  end

  assign entry_o = acc_q | mask_q;
endmodule

// File: rtl/pte_gen_addr.sv
module pte_gen_addr #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned STEP   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] StepVal = ADDR_W'(STEP);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= base_i;
    else if (step_i)  addr_q <= addr_q + StepVal;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pte_gen.sv
module pte_gen
  import pte_gen_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned CNT_W  = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  dest_i,
  input  logic [ENTRY_W-1:0] init_i,
  input  logic [ENTRY_W-1:0] incr_i,
  input  logic [ENTRY_W-1:0] mask_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic               busy_o,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [ENTRY_W-1:0] wr_data_o,
  output logic               done_o
);
  logic load, run, beat;

  assign wr_valid_o = run;
  assign beat       = run && wr_ready_i;

  pte_gen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .beat_i  (beat),
    .count_i (count_i),
    .load_o  (load),
    .run_o   (run),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  pte_gen_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (beat),
    .init_i  (init_i),
    .incr_i  (incr_i),
    .mask_i  (mask_i),
    .entry_o (wr_data_o)
  );

  pte_gen_addr #(.ADDR_W(ADDR_W), .STEP(ENTRY_BYTES)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (beat),
    .base_i (dest_i),
    .addr_o (wr_addr_o)
  );
endmodule

// File: rtl/pte_gen_chk.sv
module pte_gen_chk #(
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [63:0]       wr_data_o,
  input logic              done_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_DONE_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_valid_o && wr_ready_i)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i) |=> (!wr_valid_o || wr_addr_o == $past(wr_addr_o) + ADDR_W'(8))); // R4

  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_valid_o); // R10

  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !wr_valid_o)); // R10
endmodule

bind pte_gen pte_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .done_o     (done_o)
);

// File: tb/tb_pte_gen.sv
module tb_pte_gen;
  localparam int unsigned AW = 16;
  localparam int unsigned CW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] dest_i = '0;
  logic [63:0]   init_i = '0, incr_i = '0, mask_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          busy_o, wr_valid_o, wr_addr_dummy, done_o;
  logic          wr_ready_i = 1'b0;
  logic [AW-1:0] wr_addr_o;
  logic [63:0]   wr_data_o;

  int total = 0, bad = 0;
  int ready_mode = 0;
  int cyc = 0;
  int beats = 0;
  int done_seen = 0;
  bit expect_done = 0;
  bit stall_pend = 0;
  logic [AW-1:0] st_addr;
  logic [63:0]   st_data;
  logic [63:0]   exp_data[$];
  logic [AW-1:0] exp_addr[$];

  assign wr_addr_dummy = 1'b0;

  pte_gen #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk_i, .rst_ni, .start_i, .dest_i, .init_i, .incr_i, .mask_i, .count_i,
    .busy_o, .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o, .done_o
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ready driver
  initial forever begin
    @(posedge clk_i); #1;
    cyc++;
    case (ready_mode)
      0: wr_ready_i = 1'b1;
      1: wr_ready_i = 1'($urandom % 2);
      default: wr_ready_i = (cyc % 3 == 0);
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (stall_pend) begin
        chk(wr_valid_o == 1'b1, "R6 valid held", 64'(wr_valid_o), 64'd1);
        chk(wr_addr_o == st_addr && wr_data_o == st_data, "R6 beat stable", wr_data_o, st_data);
      end
      stall_pend = wr_valid_o && !wr_ready_i;
      st_addr = wr_addr_o;
      st_data = wr_data_o;
      if (expect_done) begin
        chk(done_o == 1'b1, "R5 done after last beat", 64'(done_o), 64'd1);
        expect_done = 0;
        done_seen++;
      end else if (done_o) begin
        chk(1'b0, "R5 unexpected done", 64'd1, 64'd0);
      end
      if (wr_valid_o) chk(busy_o, "R10 busy with valid", 64'(busy_o), 64'd1);
      if (wr_valid_o && wr_ready_i) begin
        beats++;
        if (exp_data.size() == 0) begin
          chk(1'b0, "R2 extra beat", 64'(beats), 64'd0);
        end else begin
          logic [63:0]   ed;
          logic [AW-1:0] ea;
          ed = exp_data.pop_front();
          ea = exp_addr.pop_front();
          chk(wr_data_o == ed, "R3 entry data", wr_data_o, ed);
          chk(wr_addr_o == ea, "R4 entry addr", 64'(wr_addr_o), 64'(ea));
          if (exp_data.size() == 0) expect_done = 1;
        end
      end
    end
  end

  task automatic run_cmd(input logic [AW-1:0] d, input logic [63:0] ini, input logic [63:0] inc,
                         input logic [63:0] msk, input int n, input bit poke_busy, input bit poke_done);
    int prev;
    for (int i = 0; i <= n; i++) begin
      exp_data.push_back(msk | (ini + 64'(i) * inc));
      exp_addr.push_back(d + AW'(8 * i));
    end
    beats = 0;
    prev = done_seen;
    @(posedge clk_i); #1;
    dest_i = d; init_i = ini; incr_i = inc; mask_i = msk; count_i = CW'(n);
    start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
    if (poke_busy) begin
      @(posedge clk_i); #1;
      dest_i = '1; init_i = 64'h5555; incr_i = 64'd3; mask_i = '0; count_i = '1;
      start_i = 1'b1;
      @(posedge clk_i); #1;
      start_i = 1'b0;
    end
    wait (done_seen != prev);
    chk(beats == n + 1, "R2 beat count", 64'(beats), 64'(n + 1));
    if (poke_done) begin
      start_i = 1'b1;  // still within the done cycle
      @(posedge clk_i); #1;
      start_i = 1'b0;
      repeat (3) @(negedge clk_i);
      chk(!wr_valid_o && !busy_o, "R7 start in done cycle ignored", 64'(wr_valid_o), 64'd0);
    end
    repeat (2) @(posedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!wr_valid_o && !done_o && !busy_o, "R1 reset state", 64'({wr_valid_o, done_o, busy_o}), 64'd0);

    ready_mode = 0;
    run_cmd(16'h0100, 64'h1234, 64'h10, 64'h0, 0, 0, 0);             // R9
    run_cmd(16'h0200, 64'h1000, 64'h1000, 64'h3, 5, 0, 0);            // R2 R3
    ready_mode = 1;
    run_cmd(16'h0400, 64'hA000_0000, 64'h200, 64'h8000_0000_0000_0001, 31, 0, 0);
    ready_mode = 2;
    run_cmd(16'hFFF0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 64'h0, 4, 0, 0); // R8 wrap
    run_cmd(16'h0800, 64'h0, 64'h1_0000_0001, 64'hF00, 7, 1, 0);       // R7 busy poke
    ready_mode = 1;
    run_cmd(16'h0C00, 64'h77, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3, 0, 1); // R7 done poke, R8
    ready_mode = 0;
    run_cmd(16'h1000, 64'h5, 64'h2, 64'h1, 2, 0, 0);
    chk(exp_data.size() == 0, "R2 scoreboard drained", 64'(exp_data.size()), 64'd0);
    finish_run();
  end
endmodule